// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the combinational execute stage of a 32-bit integer datapath. Each cycle it receives the primary opcode, the function field, the shift-amount field, two register operands (`src_a`, `src_b`) and a 16-bit immediate. It returns one result word without any internal state, so its output follows its inputs in the same cycle.

The unit covers shifts, add and subtract, bitwise logic, signed and unsigned compares, a low-word multiply, the immediate forms of the arithmetic and logic operations, and load-upper-immediate. Shifts come in two kinds: fixed shifts take their amount from the instruction, and variable shifts take it from the low five bits of `src_a`. Signed add and subtract raise an overflow output but still return the wrapped sum, and no trap is taken. Any encoding outside the supported set raises `bad_op_o` and forces the result to zero.

Top module: `int_exec_unit`

## Requirements
- R1: With `op_i`=000000, `fn_i` 000000 / 000010 / 000011 returns `src_b` shifted left / shifted right with zero fill / shifted right with sign fill, by `shamt_i`.
- R2: With `op_i`=000000, `fn_i` 000100 / 000110 / 000111 perform the same three shifts of `src_b`, with the amount taken from `src_a[4:0]` only. The upper bits of `src_a` are ignored.
- R3: With `op_i`=000000, `fn_i` 100000 and 100001 return `src_a + src_b`, and 100010 and 100011 return `src_a - src_b`, all modulo 2^32.
- R4: With `op_i`=000000, `fn_i` 100100 / 100101 / 100110 / 100111 return AND / OR / XOR / NOR of `src_a` and `src_b`.
- R5: With `op_i`=000000, `fn_i` 101010 returns 1 when `src_a` < `src_b` as signed numbers and 0 otherwise. `fn_i` 101011 does the same with an unsigned comparison.
- R6: `op_i`=011100 with `fn_i`=000010 returns the low 32 bits of `src_a * src_b`.
- R7: `op_i` 001000 / 001001 add the sign-extended immediate to `src_a`. `op_i` 001010 compares `src_a` with the sign-extended immediate as signed numbers. `op_i` 001011 compares against the sign-extended immediate as unsigned numbers. Both compares return 1 or 0.
- R8: `op_i` 001100 / 001101 / 001110 return AND / OR / XOR of `src_a` with the zero-extended immediate.
- R9: `op_i`=001111 returns the immediate in bits [31:16] and zero in bits [15:0].
- R10: `ovf_o` is 1 only when a signed add (`fn_i` 100000, `op_i` 001000) or a signed subtract (`fn_i` 100010) overflows two's-complement range. It is 0 for the unsigned forms and for all other operations.
- R11: Any other encoding sets `bad_op_o`=1, `result_o`=0 and `ovf_o`=0. Every supported encoding gives `bad_op_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field, used when the opcode is 000000 or 011100 |
| shamt_i | input | 5 | Fixed shift amount |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Signed add or subtract overflowed |
| bad_op_o | output | 1 | Encoding is not supported |

## Verification
Shifts are driven with a negative `src_b` at amounts 0, 1, 4 and 31. This separates zero fill from sign fill and exposes any swapped barrel stage. Variable shifts set upper `src_a` bits that must be ignored. Add and subtract are tried near both signed limits, so wrap-around with and without overflow can be told apart, and the unsigned forms must keep `ovf_o` low. Compares use a negative operand against a positive one, so signed and unsigned ordering give opposite answers. The immediate tests use an immediate with bit 15 set, which shows whether each form sign-extends or zero-extends.

// File: rtl/exu_pkg.sv
// Package: shared encodings and decoded-control type for the execute unit.
// Assumes a 6-bit opcode and a 6-bit function field.
package exu_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'b000000;
    localparam logic [5:0] OPC_MULGRP  = 6'b011100;
    localparam logic [5:0] OPC_ADDI    = 6'b001000;
    localparam logic [5:0] OPC_ADDIU   = 6'b001001;
    localparam logic [5:0] OPC_SLTI    = 6'b001010;
    localparam logic [5:0] OPC_SLTIU   = 6'b001011;
    localparam logic [5:0] OPC_ANDI    = 6'b001100;
    localparam logic [5:0] OPC_ORI     = 6'b001101;
    localparam logic [5:0] OPC_XORI    = 6'b001110;
    localparam logic [5:0] OPC_LUI     = 6'b001111;

    typedef enum logic [3:0] {
        XO_NONE, XO_SHL, XO_SHRL, XO_SHRA,
        XO_ADD, XO_ADDU, XO_SUB, XO_SUBU,
        XO_AND, XO_OR, XO_XOR, XO_NOR,
        XO_SLT, XO_SLTU, XO_MUL, XO_LUI
    } xop_e;

    typedef struct packed {
        xop_e op;        // operation to perform
        logic use_imm;   // second operand is the immediate
        logic imm_sext;  // immediate is sign-extended
        logic var_amt;   // shift amount from src_a
        logic bad;       // encoding not supported
    } xctl_t;

endpackage

// File: rtl/exu_decode.sv
// Decoder: maps opcode/function to a decoded control word.
// Assumes nothing about operands; purely a table on the two fields.
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] fn_i,
    output xctl_t      ctl_o
);

    // Purpose: decode the encoding into operation and operand selection.
    always_comb begin
        ctl_o = '{op: XO_NONE, use_imm: 1'b0, imm_sext: 1'b0, var_amt: 1'b0, bad: 1'b0};
        case (op_i)
            OPC_SPECIAL: begin
                case (fn_i)
                    6'b000000: ctl_o.op = XO_SHL;
                    6'b000010: ctl_o.op = XO_SHRL;
                    6'b000011: ctl_o.op = XO_SHRA;
                    6'b000100: begin ctl_o.op = XO_SHL;  ctl_o.var_amt = 1'b1; end
                    6'b000110: begin ctl_o.op = XO_SHRL; ctl_o.var_amt = 1'b1; end
                    6'b000111: begin ctl_o.op = XO_SHRA; ctl_o.var_amt = 1'b1; end
                    6'b100000: ctl_o.op = XO_ADD;
                    6'b100001: ctl_o.op = XO_ADDU;
                    6'b100010: ctl_o.op = XO_SUB;
                    6'b100011: ctl_o.op = XO_SUBU;
                    6'b100100: ctl_o.op = XO_AND;
                    6'b100101: ctl_o.op = XO_OR;
                    6'b100110: ctl_o.op = XO_XOR;
                    6'b100111: ctl_o.op = XO_NOR;
                    6'b101010: ctl_o.op = XO_SLT;
                    6'b101011: ctl_o.op = XO_SLTU;
                    default:   ctl_o.bad = 1'b1;
                endcase
            end
            OPC_MULGRP: begin
                if (fn_i == 6'b000010) ctl_o.op  = XO_MUL;
                else                   ctl_o.bad = 1'b1;
            end
            OPC_ADDI:  begin ctl_o.op = XO_ADD;  ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1; end
            OPC_ADDIU: begin ctl_o.op = XO_ADDU; ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1; end
            OPC_SLTI:  begin ctl_o.op = XO_SLT;  ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1; end
            OPC_SLTIU: begin ctl_o.op = XO_SLTU; ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1; end
            OPC_ANDI:  begin ctl_o.op = XO_AND;  ctl_o.use_imm = 1'b1; end
            OPC_ORI:   begin ctl_o.op = XO_OR;   ctl_o.use_imm = 1'b1; end
            OPC_XORI:  begin ctl_o.op = XO_XOR;  ctl_o.use_imm = 1'b1; end
            OPC_LUI:   begin ctl_o.op = XO_LUI;  ctl_o.use_imm = 1'b1; end
            default:   ctl_o.bad = 1'b1;
        endcase
    end

    // Purpose: a rejected encoding never carries an operation.
    always_comb begin
        // R11
        bad_has_no_op_chk: assert (!(ctl_o.bad && ctl_o.op != XO_NONE));
    end

endmodule

// File: rtl/exu_shifter.sv
// Barrel shifter: logarithmic right shifter with bit reversal for left shifts.
// Assumes W is a power of two; amt_i is already reduced to SHW bits.
module exu_shifter #(
    parameter  int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           left_i,
    input  logic           arith_i,
    output logic [W-1:0]   res_o
);

    logic [W-1:0] stage [SHW+1];
    logic         fill;

    // Purpose: reverse the input bit order for left shifts.
    always_comb begin
        for (int i = 0; i < W; i++) stage[0][i] = left_i ? val_i[W-1-i] : val_i[i];
    end

    assign fill = arith_i & ~left_i & val_i[W-1];

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            // Purpose: shift by 2^s when the matching amount bit is set.
            assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
        end
    endgenerate

    // Purpose: undo the reversal for left shifts.
    always_comb begin
        for (int i = 0; i < W; i++) res_o[i] = left_i ? stage[SHW][W-1-i] : stage[SHW][i];
    end

    // Purpose: a zero amount passes the value through unchanged.
    always_comb begin
        // R1
        zero_amt_chk: assert (!(amt_i == '0 && res_o != val_i));
    end

endmodule

// File: rtl/exu_alu.sv
// ALU: add/subtract with signed overflow, logic, compares, multiply, upper-immediate.
// Assumes b_i already carries the extended immediate when an immediate form is used.
module exu_alu
    import exu_pkg::*;
#(
    parameter  int W    = 32,
    parameter  int IMMW = 16,
    localparam int UPSH = W - IMMW
) (
    input  xop_e         op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);

    logic [W-1:0] sum, dif;
    logic         add_ovf, sub_ovf;

    assign sum     = a_i + b_i;
    assign dif     = a_i - b_i;
    assign add_ovf = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
    assign sub_ovf = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);

    // Purpose: select the result of the requested operation.
    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        case (op_i)
            XO_ADD:  begin res_o = sum; ovf_o = add_ovf; end
            XO_ADDU: res_o = sum;
            XO_SUB:  begin res_o = dif; ovf_o = sub_ovf; end
            XO_SUBU: res_o = dif;
            XO_AND:  res_o = a_i & b_i;
            XO_OR:   res_o = a_i | b_i;
            XO_XOR:  res_o = a_i ^ b_i;
            XO_NOR:  res_o = ~(a_i | b_i);
            XO_SLT:  res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            XO_SLTU: res_o = {{(W-1){1'b0}}, a_i < b_i};
            XO_MUL:  res_o = a_i * b_i;
            XO_LUI:  res_o = b_i << UPSH;
            default: res_o = '0;
        endcase
    end

    // Purpose: multiplying by one returns the other operand.
    always_comb begin
        // R6
        mul_unit_chk: assert (!(op_i == XO_MUL && b_i == 1 && res_o != a_i));
    end

endmodule

// File: rtl/int_exec_unit.sv
// Top: combinational execute stage; decodes, selects operands, and merges
// shifter and ALU results. Assumes W is a power of two and W > IMMW.
module int_exec_unit
    import exu_pkg::*;
#(
    parameter  int W    = 32,
    parameter  int IMMW = 16,
    localparam int SHW  = $clog2(W)
) (
    input  logic [5:0]      op_i,
    input  logic [5:0]      fn_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b,
    input  logic [IMMW-1:0] imm_i,
    output logic [W-1:0]    result_o,
    output logic            ovf_o,
    output logic            bad_op_o
);

    xctl_t          ctl;
    logic [W-1:0]   imm_ext, opnd_b, sh_res, alu_res;
    logic [SHW-1:0] sh_amt;
    logic           alu_ovf, is_shift;

    exu_decode u_dec (.op_i(op_i), .fn_i(fn_i), .ctl_o(ctl));

    // Purpose: extend the immediate and pick the second ALU operand.
    always_comb begin
        imm_ext = ctl.imm_sext ? {{(W-IMMW){imm_i[IMMW-1]}}, imm_i}
                               : {{(W-IMMW){1'b0}}, imm_i};
        opnd_b  = ctl.use_imm ? imm_ext : src_b;
        sh_amt  = ctl.var_amt ? src_a[SHW-1:0] : shamt_i;
    end

    assign is_shift = (ctl.op == XO_SHL) || (ctl.op == XO_SHRL) || (ctl.op == XO_SHRA);

    exu_shifter #(.W(W)) u_sh (
        .val_i(src_b), .amt_i(sh_amt),
        .left_i(ctl.op == XO_SHL), .arith_i(ctl.op == XO_SHRA),
        .res_o(sh_res)
    );

    exu_alu #(.W(W), .IMMW(IMMW)) u_alu (
        .op_i(ctl.op), .a_i(src_a), .b_i(opnd_b),
        .res_o(alu_res), .ovf_o(alu_ovf)
    );

    // Purpose: merge unit results and apply the unsupported-encoding rule.
    always_comb begin
        bad_op_o = ctl.bad;
        result_o = ctl.bad ? '0 : (is_shift ? sh_res : alu_res);
        ovf_o    = ctl.bad ? 1'b0 : alu_ovf;
    end

    // Purpose: guard output rules at the merge point.
    always_comb begin
        // R11
        bad_zero_chk: assert (!(bad_op_o && (result_o != '0 || ovf_o)));
        // R10
        ovf_signed_only_chk: assert (!(ovf_o && !(ctl.op == XO_ADD || ctl.op == XO_SUB)));
        // R5
        cmp_bit_chk: assert (!((ctl.op == XO_SLT || ctl.op == XO_SLTU) && result_o[W-1:1] != '0));
    end

endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op = '0, fn = '0;
    logic [4:0]  sh = '0;
    logic [31:0] ra = '0, rb = '0;
    logic [15:0] im = '0;
    logic [31:0] res;
    logic        ovf, bad;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    int_exec_unit dut (
        .op_i(op), .fn_i(fn), .shamt_i(sh), .src_a(ra), .src_b(rb), .imm_i(im),
        .result_o(res), .ovf_o(ovf), .bad_op_o(bad)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one encoding at a falling edge, sample mid-cycle, check all outputs.
    task automatic run(input string tag, input logic [5:0] o, input logic [5:0] f,
                       input logic [4:0] s, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, input logic [31:0] e_res,
                       input logic e_ovf, input logic e_bad);
        @(negedge clk);
        op = o; fn = f; sh = s; ra = a; rb = b; im = i;
        @(posedge clk); #1;
        chk({tag, " result"}, res, e_res);
        chk({tag, " ovf"}, {31'b0, ovf}, {31'b0, e_ovf});
        chk({tag, " bad"}, {31'b0, bad}, {31'b0, e_bad});
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic t_reset;
        @(posedge clk); #1;
        chk("R11 idle result", res, 32'h0);
        chk("R11 idle bad", {31'b0, bad}, 32'h0);
    endtask

    task automatic t_fixed_shift;   // R1
        logic [31:0] v = 32'h8421_F00D;
        run("R1 sll 4",  6'd0, 6'b000000, 5'd4,  32'hFFFF_FFFF, v, 16'h0, v << 4, 1'b0, 1'b0);
        run("R1 srl 1",  6'd0, 6'b000010, 5'd1,  32'h0, v, 16'h0, v >> 1, 1'b0, 1'b0);
        run("R1 sra 4",  6'd0, 6'b000011, 5'd4,  32'h0, v, 16'h0, 32'hF842_1F00, 1'b0, 1'b0);
        run("R1 sra 31", 6'd0, 6'b000011, 5'd31, 32'h0, v, 16'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
        run("R1 srl 0",  6'd0, 6'b000010, 5'd0,  32'h0, v, 16'h0, v, 1'b0, 1'b0);
    endtask

    task automatic t_var_shift;     // R2: upper src_a bits ignored
        logic [31:0] v = 32'h8000_0F01;
        run("R2 sllv", 6'd0, 6'b000100, 5'd0, 32'hFFFF_FFE3, v, 16'h0, v << 3, 1'b0, 1'b0);
        run("R2 srlv", 6'd0, 6'b000110, 5'd9, 32'h0000_0108, v, 16'h0, v >> 8, 1'b0, 1'b0);
        run("R2 srav", 6'd0, 6'b000111, 5'd0, 32'h1234_5670 | 32'd16, v,
            16'h0, 32'hFFFF_8000, 1'b0, 1'b0);
    endtask

    task automatic t_addsub;        // R3, R10
        run("R3 add",       6'd0, 6'b100000, 5'd0, 32'd100, 32'd23, 16'h0, 32'd123, 1'b0, 1'b0);
        run("R10 add ovf",  6'd0, 6'b100000, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h8000_0000, 1'b1, 1'b0);
        run("R10 addu",     6'd0, 6'b100001, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h8000_0000, 1'b0, 1'b0);
        run("R3 addu wrap", 6'd0, 6'b100001, 5'd0, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'd1, 1'b0, 1'b0);
        run("R10 sub ovf",  6'd0, 6'b100010, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 32'h7FFF_FFFF, 1'b1, 1'b0);
        run("R3 sub",       6'd0, 6'b100010, 5'd0, 32'd5, 32'd9, 16'h0, 32'hFFFF_FFFC, 1'b0, 1'b0);
        run("R10 subu",     6'd0, 6'b100011, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 32'h7FFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_logic;         // R4
        logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_FF00;
        run("R4 and", 6'd0, 6'b100100, 5'd0, a, b, 16'h0, a & b, 1'b0, 1'b0);
        run("R4 or",  6'd0, 6'b100101, 5'd0, a, b, 16'h0, a | b, 1'b0, 1'b0);
        run("R4 xor", 6'd0, 6'b100110, 5'd0, a, b, 16'h0, a ^ b, 1'b0, 1'b0);
        run("R4 nor", 6'd0, 6'b100111, 5'd0, a, b, 16'h0, ~(a | b), 1'b0, 1'b0);
    endtask

    task automatic t_compare;       // R5
        run("R5 slt neg<pos",  6'd0, 6'b101010, 5'd0, 32'hFFFF_FFFE, 32'd3, 16'h0, 32'd1, 1'b0, 1'b0);
        run("R5 sltu neg<pos", 6'd0, 6'b101011, 5'd0, 32'hFFFF_FFFE, 32'd3, 16'h0, 32'd0, 1'b0, 1'b0);
        run("R5 slt equal",    6'd0, 6'b101010, 5'd0, 32'd7, 32'd7, 16'h0, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_mul;           // R6
        run("R6 mul", 6'b011100, 6'b000010, 5'd0, 32'h0001_0003, 32'h0001_0005, 16'h0,
            32'h0008_000F, 1'b0, 1'b0);
        run("R6 mul neg", 6'b011100, 6'b000010, 5'd0, 32'hFFFF_FFFD, 32'd7, 16'h0,
            32'hFFFF_FFEB, 1'b0, 1'b0);
    endtask

    task automatic t_imm;           // R7, R8, R9
        logic [15:0] ni = 16'hFFF0;
        run("R7 addi",   6'b001000, 6'd0, 5'd0, 32'd100, 32'hDEAD, ni, 32'd100 + sx(ni), 1'b0, 1'b0);
        run("R7 addiu",  6'b001001, 6'd0, 5'd0, 32'd8, 32'h0, ni, 32'd8 + sx(ni), 1'b0, 1'b0);
        run("R7 slti",   6'b001010, 6'd0, 5'd0, 32'hFFFF_FF00, 32'h0, ni, 32'd1, 1'b0, 1'b0);
        run("R7 sltiu",  6'b001011, 6'd0, 5'd0, 32'hFFFF_FF00, 32'h0, ni, 32'd1, 1'b0, 1'b0);
        run("R7 sltiu2", 6'b001011, 6'd0, 5'd0, 32'hFFFF_FFF8, 32'h0, ni, 32'd0, 1'b0, 1'b0);
        run("R10 addi ovf", 6'b001000, 6'd0, 5'd0, 32'h8000_0000, 32'h0, 16'hFFFF,
            32'h7FFF_FFFF, 1'b1, 1'b0);
        run("R8 andi", 6'b001100, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8421, 32'h0000_8421, 1'b0, 1'b0);
        run("R8 ori",  6'b001101, 6'd0, 5'd0, 32'h1234_0000, 32'h0, 16'h8001, 32'h1234_8001, 1'b0, 1'b0);
        run("R8 xori", 6'b001110, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8000, 32'hFFFF_7FFF, 1'b0, 1'b0);
        run("R9 lui",  6'b001111, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF,
            32'hBEEF_0000, 1'b0, 1'b0);
    endtask

    task automatic t_unsupported;   // R11
        run("R11 jr fn",   6'd0, 6'b001000, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h0, 1'b0, 1'b1);
        run("R11 fn 101100", 6'd0, 6'b101100, 5'd0, 32'h1, 32'd1, 16'h0, 32'h0, 1'b0, 1'b1);
        run("R11 mulgrp fn", 6'b011100, 6'b000000, 5'd0, 32'h3, 32'd5, 16'h0, 32'h0, 1'b0, 1'b1);
        run("R11 load op", 6'b100011, 6'd0, 5'd0, 32'h3, 32'd5, 16'h1, 32'h0, 1'b0, 1'b1);
        run("R11 branch op", 6'b000100, 6'd0, 5'd0, 32'h3, 32'd3, 16'h1, 32'h0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_shift();
        t_var_shift();
        t_addsub();
        t_logic();
        t_compare();
        t_mul();
        t_imm();
        t_unsupported();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule